// File: doc/BRIEF.md
# Four-Channel Cell Multiplexing FIFO

This block gathers four independent 9-bit streams, each into its own 128-word buffer, and drains them one at a time through a single 9-bit output port. Data moves in fixed cells of 53 words. A sender writes a word with a per-channel strobe and marks the first word of every cell. A write that arrives at a full buffer is discarded and sets a sticky overflow flag for that channel. A write whose start marker does not match the expected cell position is also discarded.

The receiving side places a 2-bit channel number on the address input and pulses the load strobe. Once a channel is latched it stays selected until one whole cell has been read from it. Further load pulses in that time have no effect. The cell-available output shows whether the selected channel holds at least one complete cell. Each cycle with the read enable high, and a cell available, moves one word to the output register. The word appears after the next rising edge. A start-of-cell flag marks the first word of each cell. An end-of-transfer flag rises with that first word and falls on the fourth-to-last word, which warns the receiver early.

Top module: `cellmux_fifo4`

## Requirements
- R1: After reset, rd_sop, rd_ect, cell_avail and every ovf bit are 0, and the selected channel is 0.
- R2: cell_avail is 1 only while the selected channel holds a complete stored cell. It becomes 1 in the cycle after the 53rd word of a cell is written. It stays 0 after 52 words, and it stays 0 while only channels that are not selected hold cells.
- R3: A load strobe, given while no cell is in progress, latches sel_addr. From the next cycle, cell_avail reflects the new channel.
- R4: After an address is latched, load strobes are ignored until the last word of one full cell has been read from that channel. The selection therefore does not change.
- R5: A read beat takes place when rd_en = 1 and cell_avail = 1 at a rising edge. On that edge, rd_data shows the next stored word of the selected channel, in the order the words were written.
- R6: rd_sop is 1 exactly on the output cycle carrying word 0 of a cell. It is 0 on every other cycle, including stalled cycles.
- R7: rd_ect is 1 on word 0 and stays 1 up to word 48. It goes to 0 on word 49, the fourth-to-last word, and keeps its value between beats.
- R8: With rd_en low in the middle of a cell, the transfer stalls. When it resumes, the transfer continues with the next word, and none is lost or repeated.
- R9: A write to a channel that holds 128 words is dropped and sets that channel's ovf bit, which stays 1 until reset. The other channels' ovf bits are unaffected.
- R10: A write is dropped without setting ovf in two cases. The first is a marker wr_sop = 1 at a position other than word 0 of a cell. The second is wr_sop = 0 at word 0.
- R11: rd_en = 1 while cell_avail = 0 changes neither rd_data nor rd_ect, and rd_sop stays 0. The next cell read starts at word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 4 | Per-channel write strobe |
| wr_sop | input | 4 | Per-channel first-word-of-cell marker |
| wr_data | input | 36 | Write data, channel i at bits 9i+8..9i |
| sel_addr | input | 2 | Channel number to select |
| sel_load | input | 1 | Load strobe for sel_addr |
| rd_en | input | 1 | Read enable, one word per beat |
| rd_data | output | 9 | Output word |
| rd_sop | output | 1 | Start-of-cell flag for rd_data |
| rd_ect | output | 1 | End-of-cell-transfer warning flag |
| cell_avail | output | 1 | Selected channel holds a complete cell |
| ovf | output | 4 | Sticky per-channel overflow flags |

## Verification
The assertions assume the receiver keeps two rules. It loads only a channel that already holds a complete cell, and it raises rd_en only while cell_avail is 1, except where a test checks on purpose that a read without a cell has no effect. The stimulus keeps these rules by following a per-channel model of the stored words. It loads a channel only after a full cell has been written to it. It issues exactly 53 read beats per cell, with optional stalls. Writes that the bench expects to be dropped are kept out of the model, so the read data shows whether the drop happened.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
    localparam int unsigned CMF_CH    = 4;
    localparam int unsigned CMF_W     = 9;
    localparam int unsigned CMF_DEPTH = 128;
    localparam int unsigned CMF_CELL  = 53;
    localparam int unsigned CMF_WARN  = 4;
endpackage

// File: rtl/cmf_chan.sv
// One channel buffer: word storage, cell framing on both sides, cell count.
module cmf_chan #(
    parameter int unsigned W     = 9,
    parameter int unsigned DEPTH = 128,   // power of two
    parameter int unsigned CELL  = 53
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_sop,
    input  logic [W-1:0]            wr_data,
    input  logic                    rd_go,
    output logic [W-1:0]            head_data,
    output logic [$clog2(CELL)-1:0] head_pos,
    output logic                    cell_ready,
    output logic                    ovf
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned PW = $clog2(CELL);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] words;
        logic [CW-1:0] cells;
        logic [PW-1:0] ipos;
        logic [PW-1:0] opos;
        logic          ovf;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic full_w, take_w, in_end_w, out_end_w;

    always_comb begin
        full_w    = (st_q.words == CW'(DEPTH));
        take_w    = wr_en && !full_w && (wr_sop == (st_q.ipos == '0));
        in_end_w  = take_w && (st_q.ipos == PW'(CELL - 1));
        out_end_w = rd_go && (st_q.opos == PW'(CELL - 1));
        st_d      = st_q;
        if (take_w) begin
            st_d.wptr = st_q.wptr + 1'b1;
            st_d.ipos = in_end_w ? '0 : st_q.ipos + 1'b1;
        end
        if (rd_go) begin
            st_d.rptr = st_q.rptr + 1'b1;
            st_d.opos = out_end_w ? '0 : st_q.opos + 1'b1;
        end
        st_d.words = st_q.words + CW'(take_w) - CW'(rd_go);
        st_d.cells = st_q.cells + CW'(in_end_w) - CW'(out_end_w);
        if (wr_en && full_w) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (take_w) begin
            mem[st_q.wptr] <= wr_data;
        end
    end

    assign head_data  = mem[st_q.rptr];
    assign head_pos   = st_q.opos;
    assign cell_ready = (st_q.cells != '0);
    assign ovf        = st_q.ovf;

    // R2: the selector only reads while a complete cell is stored
    p_read_needs_cell_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |-> (st_q.cells != '0));
    // R9: the word count never exceeds the storage depth
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.words <= CW'(DEPTH));
    // R9: a write into a full buffer does not advance the write pointer
    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full_w) |=> $stable(st_q.wptr));
endmodule

// File: rtl/cmf_sel.sv
// Channel address latch with cell-granular lockout.
module cmf_sel #(
    parameter int unsigned CH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [$clog2(CH)-1:0] sel_addr,
    input  logic                  sel_load,
    input  logic                  pos_zero,
    input  logic                  cell_end,
    output logic [$clog2(CH)-1:0] sel
);
    localparam int unsigned SW = $clog2(CH);

    typedef struct packed {
        logic [SW-1:0] sel;
        logic          lk;
    } sel_st_t;

    sel_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_load && !st_q.lk && pos_zero) begin
            st_d.sel = sel_addr;
            st_d.lk  = 1'b1;
        end else if (cell_end) begin
            st_d.lk  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel = st_q.sel;

    // R4: while locked and no cell finishes, the address holds
    p_addr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lk && !cell_end) |=> $stable(st_q.sel));
endmodule

// File: rtl/cmf_out.sv
// Output register with start-of-cell and early end-of-cell flags.
module cmf_out #(
    parameter int unsigned W    = 9,
    parameter int unsigned CELL = 53,
    parameter int unsigned WARN = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    beat,
    input  logic [W-1:0]            head_data,
    input  logic [$clog2(CELL)-1:0] head_pos,
    output logic [W-1:0]            rd_data,
    output logic                    rd_sop,
    output logic                    rd_ect
);
    localparam int unsigned PW = $clog2(CELL);

    typedef struct packed {
        logic [W-1:0] data;
        logic         sop;
        logic         ect;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sop = 1'b0;
        if (beat) begin
            st_d.data = head_data;
            st_d.sop  = (head_pos == '0);
            st_d.ect  = (head_pos < PW'(CELL - WARN));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.data;
    assign rd_sop  = st_q.sop;
    assign rd_ect  = st_q.ect;

    // R7: start of cell always comes with the transfer flag high
    p_sop_with_ect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sop |-> rd_ect);
    // R7: the flag falls only on a beat that is not a first word
    p_ect_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_ect) |-> (!rd_sop && $past(beat)));
    // R6: start of cell only follows a beat
    p_sop_on_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sop |-> $past(beat));
endmodule

// File: rtl/cellmux_fifo4.sv
module cellmux_fifo4
    import cmf_pkg::*;
#(
    parameter int unsigned CH    = CMF_CH,
    parameter int unsigned W     = CMF_W,
    parameter int unsigned DEPTH = CMF_DEPTH,
    parameter int unsigned CELL  = CMF_CELL,
    parameter int unsigned WARN  = CMF_WARN
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CH-1:0]         wr_en,
    input  logic [CH-1:0]         wr_sop,
    input  logic [CH*W-1:0]       wr_data,
    input  logic [$clog2(CH)-1:0] sel_addr,
    input  logic                  sel_load,
    input  logic                  rd_en,
    output logic [W-1:0]          rd_data,
    output logic                  rd_sop,
    output logic                  rd_ect,
    output logic                  cell_avail,
    output logic [CH-1:0]         ovf
);
    localparam int unsigned SW = $clog2(CH);
    localparam int unsigned PW = $clog2(CELL);

    logic [W-1:0]  hd   [CH];
    logic [PW-1:0] hp   [CH];
    logic [CH-1:0] rdy;
    logic [CH-1:0] go;
    logic [SW-1:0] sel;
    logic          beat;
    logic          pos_zero;
    logic          cell_end;

    for (genvar i = 0; i < CH; i++) begin : g_chan
        cmf_chan #(.W(W), .DEPTH(DEPTH), .CELL(CELL)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_en[i]),
            .wr_sop     (wr_sop[i]),
            .wr_data    (wr_data[i*W +: W]),
            .rd_go      (go[i]),
            .head_data  (hd[i]),
            .head_pos   (hp[i]),
            .cell_ready (rdy[i]),
            .ovf        (ovf[i])
        );
        assign go[i] = beat && (sel == SW'(i));
    end

    assign cell_avail = rdy[sel];
    assign beat       = rd_en && cell_avail;
    assign pos_zero   = (hp[sel] == '0);
    assign cell_end   = beat && (hp[sel] == PW'(CELL - 1));

    cmf_sel #(.CH(CH)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_addr (sel_addr),
        .sel_load (sel_load),
        .pos_zero (pos_zero),
        .cell_end (cell_end),
        .sel      (sel)
    );

    cmf_out #(.W(W), .CELL(CELL), .WARN(WARN)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat      (beat),
        .head_data (hd[sel]),
        .head_pos  (hp[sel]),
        .rd_data   (rd_data),
        .rd_sop    (rd_sop),
        .rd_ect    (rd_ect)
    );

    // R9: overflow flags never clear once set
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ovf & $past(ovf)) == $past(ovf)));
    // R11: with no cell available the output data holds
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_avail |=> $stable(rd_data));
endmodule

// File: tb/cellmux_fifo4_test.sv
module cellmux_fifo4_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  wr_en = '0;
    logic [3:0]  wr_sop = '0;
    logic [35:0] wr_data = '0;
    logic [1:0]  sel_addr = '0;
    logic        sel_load = 1'b0;
    logic        rd_en = 1'b0;
    logic [8:0]  rd_data;
    logic        rd_sop, rd_ect, cell_avail;
    logic [3:0]  ovf;

    cellmux_fifo4 uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sop(wr_sop),
        .wr_data(wr_data), .sel_addr(sel_addr), .sel_load(sel_load),
        .rd_en(rd_en), .rd_data(rd_data), .rd_sop(rd_sop), .rd_ect(rd_ect),
        .cell_avail(cell_avail), .ovf(ovf)
    );

    always #5 clk = ~clk;

    typedef struct { logic [8:0] d; logic s; logic e; } exp_t;
    exp_t       eq [$];
    logic [8:0] mq [4][$];
    int         n_chk = 0;
    int         n_bad = 0;
    int         cyc = 0;
    int         cur_ch = 0;
    logic       beat_req = 1'b0;
    logic       bq = 1'b0;
    logic [8:0] last_d = '0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            report();
        end
    end

    // monitor: compare every beat against the scoreboard
    always @(posedge clk) bq <= beat_req;
    always @(negedge clk) begin
        if (bq) begin
            exp_t e;
            e = eq.pop_front();
            chk("R5 data", int'(rd_data), int'(e.d));
            chk("R6 sop", int'(rd_sop), int'(e.s));
            chk("R7 ect", int'(rd_ect), int'(e.e));
            last_d = e.d;
        end
    end

    task automatic wr_word(input int ch, input logic [8:0] d, input logic sop, input bit keep);
        @(negedge clk);
        wr_en = '0;
        wr_en[ch] = 1'b1;
        wr_sop = '0;
        wr_sop[ch] = sop;
        wr_data[ch*9 +: 9] = d;
        if (keep) mq[ch].push_back(d);
        @(posedge clk);
    endtask

    task automatic wr_idle();
        @(negedge clk);
        wr_en = '0;
        wr_sop = '0;
    endtask

    task automatic write_words(input int ch, input int base, input int from, input int upto);
        for (int j = from; j <= upto; j++) wr_word(ch, 9'(base + j), j == 0, 1'b1);
        wr_idle();
    endtask

    task automatic load(input int a);
        @(negedge clk);
        sel_addr = 2'(a);
        sel_load = 1'b1;
        cur_ch = a;
        @(posedge clk);
        @(negedge clk);
        sel_load = 1'b0;
    endtask

    task automatic read_cell(input int stall_at, input int poke_at);
        for (int j = 0; j < 53; j++) begin
            @(negedge clk);
            sel_load = 1'b0;
            if (j == poke_at + 1) chk("R4 avail held", int'(cell_avail), 1);
            if (j == stall_at) begin
                rd_en = 1'b0;
                beat_req = 1'b0;
                repeat (3) begin
                    @(posedge clk);
                    @(negedge clk);
                end
                chk("R8 sop low in stall", int'(rd_sop), 0);
                chk("R8 data held in stall", int'(rd_data), int'(last_d));
            end
            if (j == poke_at) begin
                sel_addr = 2'd0;
                sel_load = 1'b1;
            end
            rd_en = 1'b1;
            beat_req = 1'b1;
            eq.push_back('{mq[cur_ch].pop_front(), j == 0, j < 49});
            @(posedge clk);
        end
        @(negedge clk);
        rd_en = 1'b0;
        beat_req = 1'b0;
        sel_load = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sop", int'(rd_sop), 0);
        chk("R1 ect", int'(rd_ect), 0);
        chk("R1 avail", int'(cell_avail), 0);
        chk("R1 ovf", int'(ovf), 0);

        // R2: 52 words are not a cell
        write_words(0, 9'h100, 0, 51);
        chk("R2 partial cell", int'(cell_avail), 0);
        // R2: a full cell in an unselected channel is not visible
        write_words(2, 9'h040, 0, 52);
        chk("R2 unselected", int'(cell_avail), 0);

        // R3: load channel 2
        load(2);
        chk("R3 avail after load", int'(cell_avail), 1);
        // R4, R8: stall mid cell and poke a load to channel 0
        read_cell(10, 30);
        chk("R2 drained", int'(cell_avail), 0);

        // finish channel 0 cell; selection must still be channel 2 (R4)
        write_words(0, 9'h100, 52, 52);
        chk("R4 load ignored", int'(cell_avail), 0);
        load(0);
        chk("R3 avail ch0", int'(cell_avail), 1);
        read_cell(-1, -1);

        // R11: read enable with nothing available
        @(negedge clk);
        rd_en = 1'b1;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
        end
        chk("R11 data", int'(rd_data), int'(last_d));
        chk("R11 sop", int'(rd_sop), 0);
        chk("R11 ect", int'(rd_ect), 0);
        rd_en = 1'b0;
        write_words(0, 9'h0a0, 0, 52);
        load(0);
        read_cell(-1, -1);

        // R10: marker mismatches are dropped
        wr_word(1, 9'h1ff, 1'b0, 1'b0);
        for (int j = 0; j < 53; j++) begin
            if (j == 20) wr_word(1, 9'h1ee, 1'b1, 1'b0);
            wr_word(1, 9'(9'h010 + j), j == 0, 1'b1);
        end
        wr_idle();
        chk("R10 no ovf", int'(ovf[1]), 0);
        load(1);
        chk("R10 avail", int'(cell_avail), 1);
        read_cell(-1, -1);

        // R9: fill channel 3 to 128 words then overrun
        write_words(3, 9'h000, 0, 52);
        write_words(3, 9'h035, 0, 52);
        write_words(3, 9'h06a, 0, 21);
        for (int j = 0; j < 3; j++) wr_word(3, 9'h1aa, 1'b0, 1'b0);
        wr_idle();
        chk("R9 ovf only ch3", int'(ovf), 8);
        load(3);
        read_cell(-1, -1);
        load(3);
        read_cell(-1, -1);
        write_words(3, 9'h06a, 22, 52);
        load(3);
        chk("R9 third cell avail", int'(cell_avail), 1);
        read_cell(-1, -1);
        chk("R9 ovf sticky", int'(ovf), 8);
        chk("R2 all drained", int'(cell_avail), 0);

        repeat (2) @(negedge clk);
        report();
    end
endmodule